// File: doc/BRIEF.md
# Windowed Backplane Address Translator

This block connects a host that sees only a narrow aperture to a 32-bit internal backplane. The host has two ports. A byte-wide configuration port holds the window registers. A memory port reaches a 2 KB aperture. The configuration registers hold the upper 20 bits of a 4 KB core window, plus one segment bit. The segment bit picks which half of that core window the aperture shows. Each host memory access is turned into one or two backplane transactions. Each transaction carries a full 32-bit address and byte enables. The host is held off by a wait signal until the backplane has acknowledged every part of the access.

Host software moves the window by writing the window registers. It reads them back to confirm the switch, then issues memory accesses. A 32-bit host access travels as two 16-bit backplane transactions. The low half goes first. Window and segment values are sampled when an access is accepted. A later register write therefore never disturbs an access that is already running.

Top module: `win_xlate`

## Requirements
- R1: After a synchronous reset, every window register and the segment register read back as zero. `mem_wait` and `bp_req` are low.
- R2: Config address 0x2E stores backplane address bits 15:12 in its low nibble, and its upper nibble reads as zero. Address 0x30 stores bits 23:16 and address 0x32 stores bits 31:24. Each register reads back the value last written.
- R3: Config address 0x34 is the segment register. It stores only bit 0 of the written byte and reads back as 0x00 or 0x01.
- R4: Writes to any other config address change no register, and such addresses read as zero.
- R5: The backplane address is {window bits 31:12, segment, 11-bit host offset}. So in segment 1, host offset X reaches core offset 0x800+X.
- R6: A byte access (`mem_size` 2'b00) issues one transaction. Its byte enable is 1 shifted left by offset bits 1:0. The write byte is replicated on all four lanes. Read data is the addressed lane, zero-extended.
- R7: A half-word access (`mem_size` 2'b01) issues one transaction. Its enables are 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1. The write half is replicated on both halves. Read data is the selected half, zero-extended.
- R8: A word access (`mem_size` bit 1 set) issues two half-word transactions. The first is at the offset and carries data bits 15:0. The second is at offset+2, taken modulo 2 KB, and carries bits 31:16. The read result joins the two halves, with the first in bits 15:0.
- R9: A backplane request holds its address, enables, direction and data stable until `bp_ack`. `mem_wait` is high from the cycle after acceptance until the cycle after the last acknowledge.
- R10: Window and segment values are captured when a request is accepted. A config write in that same cycle, or while the access is in flight, affects only later accesses.
- R11: A `mem_req` raised while `mem_wait` is high is ignored and produces no backplane transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 8 | Config register address (also selects readback) |
| cfg_wdata | input | 8 | Config write byte |
| cfg_rdata | output | 8 | Config readback byte for `cfg_addr` |
| mem_req | input | 1 | One-cycle memory access request, accepted when idle |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_size | input | 2 | 00 byte, 01 half-word, 1x word |
| mem_off | input | 11 | Offset inside the host aperture |
| mem_wdata | input | 32 | Host write data, right-aligned |
| mem_rdata | output | 32 | Host read data, valid when `mem_wait` falls |
| mem_wait | output | 1 | Access in progress |
| bp_req | output | 1 | Backplane transaction request |
| bp_we | output | 1 | Backplane write |
| bp_addr | output | 32 | Backplane byte address |
| bp_be | output | 4 | Backplane byte enables |
| bp_wdata | output | 32 | Backplane write data |
| bp_rdata | input | 32 | Backplane read data, valid with `bp_ack` |
| bp_ack | input | 1 | Backplane acknowledge |

## Verification
Two functions can fall in the same clock edge: a config write that moves the window or segment, and the acceptance of a memory request. The bench drives both in one cycle. It also issues a config write while an access waits on a slow acknowledge. The bench's reference model keeps a shadow of the window registers and computes each expected backplane address from the shadow as it stood before the write. Any transaction that already uses the new window value is reported as a miscompare, and so is any extra transaction caused by a request raised during the wait.

// File: rtl/win_xlate_pkg.sv
package win_xlate_pkg;

    localparam int BP_AW  = 32;                 // backplane address width
    localparam int AP_W   = 11;                 // host aperture offset width
    localparam int WIN_W  = BP_AW - AP_W - 1;   // window bits above the segment bit
    localparam int WA_W   = WIN_W - 16;         // nibble held in the lowest window register
    localparam int CFG_AW = 8;
    localparam int CFG_DW = 8;
    localparam int HDW    = 32;                 // host and backplane data width
    localparam int BEW    = HDW / 8;

    localparam logic [CFG_AW-1:0] CA_WIN_A = 8'h2E;
    localparam logic [CFG_AW-1:0] CA_WIN_B = 8'h30;
    localparam logic [CFG_AW-1:0] CA_WIN_C = 8'h32;
    localparam logic [CFG_AW-1:0] CA_SEG   = 8'h34;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} xstate_e;

    typedef struct packed {
        logic             we;
        logic [1:0]       size;
        logic [AP_W-1:0]  off;
        logic [HDW-1:0]   wdata;
        logic [WIN_W-1:0] win;
        logic             seg;
    } xact_t;

    function automatic logic is_word(input logic [1:0] s);
        return s[1];
    endfunction

    function automatic logic [BEW-1:0] lane_mask(input logic [1:0] s, input logic [1:0] a);
        if (s == SZ_BYTE) return BEW'(4'b0001 << a);
        return a[1] ? 4'b1100 : 4'b0011;
    endfunction

    function automatic logic [15:0] half_pick(input logic [HDW-1:0] d, input logic a1);
        return a1 ? d[31:16] : d[15:0];
    endfunction

    function automatic logic [7:0] byte_pick(input logic [HDW-1:0] d, input logic [1:0] a);
        logic [HDW-1:0] t;
        t = d >> {a, 3'b000};
        return t[7:0];
    endfunction

endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic [WIN_W-1:0]  win,
    output logic              seg
);

    logic [WA_W-1:0]   r_a;
    logic [CFG_DW-1:0] r_b;
    logic [CFG_DW-1:0] r_c;
    logic              r_seg;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_a   <= '0;
            r_b   <= '0;
            r_c   <= '0;
            r_seg <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CA_WIN_A: r_a   <= cfg_wdata[WA_W-1:0];
                CA_WIN_B: r_b   <= cfg_wdata;
                CA_WIN_C: r_c   <= cfg_wdata;
                CA_SEG:   r_seg <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CA_WIN_A: cfg_rdata[WA_W-1:0] = r_a;
            CA_WIN_B: cfg_rdata           = r_b;
            CA_WIN_C: cfg_rdata           = r_c;
            CA_SEG:   cfg_rdata[0]        = r_seg;
            default:  cfg_rdata           = '0;
        endcase
    end

    assign win = {r_c, r_b, r_a};
    assign seg = r_seg;

endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
    import win_xlate_pkg::*;
(
    input  xact_t             x,
    input  logic              upper,
    output logic [BP_AW-1:0]  addr,
    output logic [BEW-1:0]    be,
    output logic [HDW-1:0]    wdata
);

    logic [AP_W-1:0] off_eff;

    always_comb begin
        off_eff = upper ? x.off + AP_W'(2) : x.off;
        addr    = {x.win, x.seg, off_eff};
        be      = lane_mask(x.size, off_eff[1:0]);
        if (x.size == SZ_BYTE)
            wdata = {BEW{x.wdata[7:0]}};
        else if (upper)
            wdata = {(BEW/2){x.wdata[31:16]}};
        else
            wdata = {(BEW/2){x.wdata[15:0]}};
    end

endmodule

// File: rtl/win_xfer_fsm.sv
module win_xfer_fsm
    import win_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_req,
    input  logic             mem_we,
    input  logic [1:0]       mem_size,
    input  logic [AP_W-1:0]  mem_off,
    input  logic [HDW-1:0]   mem_wdata,
    input  logic [WIN_W-1:0] win,
    input  logic             seg,
    input  logic             bp_ack,
    input  logic [HDW-1:0]   bp_rdata,
    input  logic [1:0]       lane_off,
    output xact_t            x,
    output logic             upper,
    output logic             bp_req,
    output logic             mem_wait,
    output logic [HDW-1:0]   mem_rdata
);

    xstate_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            x         <= '0;
            mem_rdata <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (mem_req) begin
                        x  <= '{we: mem_we, size: mem_size, off: mem_off,
                                wdata: mem_wdata, win: win, seg: seg};
                        st <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (bp_ack) begin
                        if (!x.we) begin
                            if (x.size == SZ_BYTE)
                                mem_rdata <= HDW'(byte_pick(bp_rdata, lane_off));
                            else if (is_word(x.size))
                                mem_rdata[15:0] <= half_pick(bp_rdata, lane_off[1]);
                            else
                                mem_rdata <= HDW'(half_pick(bp_rdata, lane_off[1]));
                        end
                        st <= is_word(x.size) ? ST_HIGH : ST_IDLE;
                    end
                end
                ST_HIGH: begin
                    if (bp_ack) begin
                        if (!x.we)
                            mem_rdata[31:16] <= half_pick(bp_rdata, lane_off[1]);
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bp_req   = (st != ST_IDLE);
    assign mem_wait = (st != ST_IDLE);
    assign upper    = (st == ST_HIGH);

endmodule

// File: rtl/win_xlate.sv
module win_xlate
    import win_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [1:0]        mem_size,
    input  logic [AP_W-1:0]   mem_off,
    input  logic [HDW-1:0]    mem_wdata,
    output logic [HDW-1:0]    mem_rdata,
    output logic              mem_wait,
    output logic              bp_req,
    output logic              bp_we,
    output logic [BP_AW-1:0]  bp_addr,
    output logic [BEW-1:0]    bp_be,
    output logic [HDW-1:0]    bp_wdata,
    input  logic [HDW-1:0]    bp_rdata,
    input  logic              bp_ack
);

    logic [WIN_W-1:0] win;
    logic             seg;
    xact_t            x;
    logic             upper;

    win_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win       (win),
        .seg       (seg)
    );

    win_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_off   (mem_off),
        .mem_wdata (mem_wdata),
        .win       (win),
        .seg       (seg),
        .bp_ack    (bp_ack),
        .bp_rdata  (bp_rdata),
        .lane_off  (bp_addr[1:0]),
        .x         (x),
        .upper     (upper),
        .bp_req    (bp_req),
        .mem_wait  (mem_wait),
        .mem_rdata (mem_rdata)
    );

    win_addr_gen u_agen (
        .x     (x),
        .upper (upper),
        .addr  (bp_addr),
        .be    (bp_be),
        .wdata (bp_wdata)
    );

    assign bp_we = x.we;

endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk
    import win_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_rdata,
    input logic              mem_wait,
    input logic              bp_req,
    input logic              bp_ack,
    input logic              bp_we,
    input logic [BP_AW-1:0]  bp_addr,
    input logic [BEW-1:0]    bp_be,
    input logic [HDW-1:0]    bp_wdata
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bp_req && !mem_wait));

    assert_nibble_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == CA_WIN_A) |-> (cfg_rdata[7:4] == 4'h0));

    assert_seg_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == CA_SEG) |-> (cfg_rdata[7:1] == 7'h0));

    assert_lane_shape_R7: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> ($countones(bp_be) == 1 || bp_be == 4'b0011 || bp_be == 4'b1100));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (bp_req && !bp_ack) |=> (bp_req && $stable(bp_addr) && $stable(bp_be)
                                 && $stable(bp_we) && $stable(bp_wdata)));

    assert_wait_covers_req_R9: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> mem_wait);

endmodule

bind win_xlate win_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .mem_wait  (mem_wait),
    .bp_req    (bp_req),
    .bp_ack    (bp_ack),
    .bp_we     (bp_we),
    .bp_addr   (bp_addr),
    .bp_be     (bp_be),
    .bp_wdata  (bp_wdata)
);

// File: tb/win_xlate_bench.sv
`timescale 1ns/1ps
module win_xlate_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
    logic        mem_req, mem_we;
    logic [1:0]  mem_size;
    logic [10:0] mem_off;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_wait;
    logic        bp_req, bp_we;
    logic [31:0] bp_addr, bp_wdata, bp_rdata;
    logic [3:0]  bp_be;
    logic        bp_ack;

    always #2.5 clk = ~clk;

    win_xlate u_win_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .bp_req(bp_req), .bp_we(bp_we), .bp_addr(bp_addr), .bp_be(bp_be),
        .bp_wdata(bp_wdata), .bp_rdata(bp_rdata), .bp_ack(bp_ack)
    );

    int vecs = 0;
    int fails = 0;
    bit done = 0;
    int lat = 0;
    int cnt = 0;

    logic [7:0]  mem_b [logic [31:0]];
    logic [31:0] q_addr [$];
    logic [3:0]  q_be   [$];
    logic        q_we   [$];
    logic [31:0] q_wd   [$];

    logic [3:0] sh_a;
    logic [7:0] sh_b, sh_c;
    logic       sh_seg;

    logic [31:0] s_base, s_rd, e_addr, e_wd;
    logic [3:0]  e_be;
    logic        e_we;
    logic [31:0] rd;

    function automatic logic [7:0] mb(input logic [31:0] a);
        if (mem_b.exists(a)) return mem_b[a];
        return a[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] ref_half(input logic [31:0] a);
        logic [31:0] b;
        b = {a[31:2], 2'b00} + {30'd0, a[1], 1'b0};
        return {mb(b + 1), mb(b)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%h expected 0x%h", req, what, act, exp);
        end
    endtask

    task automatic shadow_upd(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h2E: sh_a = d[3:0];
            8'h30: sh_b = d;
            8'h32: sh_c = d;
            8'h34: sh_seg = d[0];
            default: ;
        endcase
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        shadow_upd(a, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, "config readback", {24'd0, cfg_rdata}, {24'd0, exp});
    endtask

    task automatic push(input logic [31:0] a, input logic [3:0] be,
                        input logic we, input logic [31:0] wd);
        q_addr.push_back(a); q_be.push_back(be); q_we.push_back(we); q_wd.push_back(wd);
    endtask

    // Backplane slave with programmable latency; checks each transaction against the model queue
    always @(negedge clk) begin
        if (rst) begin
            bp_ack = 1'b0; cnt = 0; bp_rdata = '0;
        end else begin
            vecs++;
            if (bp_req && !mem_wait) begin
                fails++;
                $display("FAIL R9 request outside wait: actual 0x%h expected 0x%h", mem_wait, 1'b1);
            end
            if (bp_ack) begin
                bp_ack = 1'b0; cnt = 0;
            end else if (bp_req) begin
                if (cnt >= lat) begin
                    if (q_addr.size() == 0) begin
                        fails++;
                        $display("FAIL R11 unexpected backplane transaction: actual 0x%h expected 0x%h",
                                 bp_addr, 32'h0);
                    end else begin
                        e_addr = q_addr.pop_front(); e_be = q_be.pop_front();
                        e_we = q_we.pop_front(); e_wd = q_wd.pop_front();
                        chk("R5", "backplane address", bp_addr, e_addr);
                        chk("R7", "byte enables", {28'd0, bp_be}, {28'd0, e_be});
                        chk("R8", "direction", {31'd0, bp_we}, {31'd0, e_we});
                        if (e_we) chk("R6", "write lanes", bp_wdata, e_wd);
                    end
                    s_base = {bp_addr[31:2], 2'b00};
                    for (int i = 0; i < 4; i++) begin
                        if (bp_we && bp_be[i]) mem_b[s_base + i] = bp_wdata[8*i +: 8];
                        s_rd[8*i +: 8] = mb(s_base + i);
                    end
                    bp_rdata = s_rd;
                    bp_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic mem_op(input logic we, input logic [1:0] sz, input logic [10:0] off,
                          input logic [31:0] wd, input string req,
                          input bit clash_cfg, input bit mid_cfg, input bit poke,
                          input logic [7:0] ca, input logic [7:0] cd,
                          output logic [31:0] res);
        logic [31:0] a1, a2, exp;
        int guard;
        @(negedge clk);
        a1 = {sh_c, sh_b, sh_a, sh_seg, off};
        a2 = {sh_c, sh_b, sh_a, sh_seg, off + 11'd2};
        if (sz == 2'b00) begin
            push(a1, 4'b0001 << off[1:0], we, {4{wd[7:0]}});
            exp = {24'd0, mb(a1)};
        end else if (!sz[1]) begin
            push(a1, off[1] ? 4'b1100 : 4'b0011, we, {2{wd[15:0]}});
            exp = {16'd0, ref_half(a1)};
        end else begin
            push(a1, off[1] ? 4'b1100 : 4'b0011, we, {2{wd[15:0]}});
            push(a2, a2[1] ? 4'b1100 : 4'b0011, we, {2{wd[31:16]}});
            exp = {ref_half(a2), ref_half(a1)};
        end
        mem_req = 1'b1; mem_we = we; mem_size = sz; mem_off = off; mem_wdata = wd;
        if (clash_cfg) begin
            cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd; shadow_upd(ca, cd);
        end
        @(negedge clk);
        mem_req = 1'b0; cfg_we = 1'b0;
        chk("R9", "wait after accept", {31'd0, mem_wait}, 32'd1);
        if (mid_cfg) begin
            cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd; shadow_upd(ca, cd);
        end
        if (poke) begin
            mem_req = 1'b1; mem_we = ~we; mem_size = 2'b00; mem_off = off ^ 11'h040;
        end
        @(negedge clk);
        cfg_we = 1'b0; mem_req = 1'b0;
        guard = 0;
        while (mem_wait && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 1000) chk("R9", "access never completed", 32'd1, 32'd0);
        if (!we) chk(req, "read data", mem_rdata, exp);
        chk("R8", "transactions left", q_addr.size(), 32'd0);
        res = mem_rdata;
    endtask

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual 0x%h expected 0x%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mem_req = 1'b0; mem_we = 1'b0; mem_size = '0; mem_off = '0; mem_wdata = '0;
        sh_a = '0; sh_b = '0; sh_c = '0; sh_seg = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cfg_chk(8'h2E, 8'h00, "R1"); cfg_chk(8'h30, 8'h00, "R1");
        cfg_chk(8'h32, 8'h00, "R1"); cfg_chk(8'h34, 8'h00, "R1");
        chk("R1", "wait after reset", {31'd0, mem_wait}, 32'd0);
        chk("R1", "request after reset", {31'd0, bp_req}, 32'd0);

        // R2: window registers
        cfg_wr(8'h2E, 8'hFB); cfg_chk(8'h2E, 8'h0B, "R2");
        cfg_wr(8'h30, 8'h12); cfg_wr(8'h32, 8'h81);
        cfg_chk(8'h30, 8'h12, "R2"); cfg_chk(8'h32, 8'h81, "R2");

        // R3: segment keeps bit 0
        cfg_wr(8'h34, 8'h03); cfg_chk(8'h34, 8'h01, "R3");
        cfg_wr(8'h34, 8'h02); cfg_chk(8'h34, 8'h00, "R3");
        cfg_wr(8'h34, 8'hFF); cfg_chk(8'h34, 8'h01, "R3");

        // R4: unmapped addresses
        cfg_wr(8'h2F, 8'hFF); cfg_wr(8'h31, 8'h77); cfg_wr(8'h40, 8'h55);
        cfg_chk(8'h2F, 8'h00, "R4"); cfg_chk(8'h40, 8'h00, "R4");
        cfg_chk(8'h2E, 8'h0B, "R4"); cfg_chk(8'h30, 8'h12, "R4");
        cfg_chk(8'h32, 8'h81, "R4"); cfg_chk(8'h34, 8'h01, "R4");

        // R5, R6: byte accesses in segment 1
        lat = 0;
        for (int k = 0; k < 4; k++)
            mem_op(1'b1, 2'b00, 11'h010 + 11'(k), {24'd0, 8'(8'h11 * (k + 1))}, "R6",
                   0, 0, 0, 8'h00, 8'h00, rd);
        mem_op(1'b0, 2'b00, 11'h012, '0, "R6", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R6", "byte lane 2", rd, 32'h0000_0033);
        mem_op(1'b0, 2'b10, 11'h010, '0, "R5", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R5", "segment 1 word", rd, 32'h4433_2211);

        // R7, R8: half and word in segment 0
        cfg_wr(8'h34, 8'h00);
        mem_op(1'b1, 2'b01, 11'h100, 32'h0000_BEEF, "R7", 0, 0, 0, 8'h00, 8'h00, rd);
        mem_op(1'b1, 2'b01, 11'h102, 32'h0000_CAFE, "R7", 0, 0, 0, 8'h00, 8'h00, rd);
        mem_op(1'b0, 2'b10, 11'h100, '0, "R8", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R8", "joined word", rd, 32'hCAFE_BEEF);

        lat = 2;
        mem_op(1'b1, 2'b10, 11'h200, 32'h1234_5678, "R8", 0, 0, 0, 8'h00, 8'h00, rd);
        mem_op(1'b0, 2'b01, 11'h202, '0, "R7", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R7", "upper half", rd, 32'h0000_1234);
        mem_op(1'b0, 2'b00, 11'h201, '0, "R6", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R6", "byte lane 1", rd, 32'h0000_0056);

        // R8: second half wraps inside the aperture
        mem_op(1'b1, 2'b11, 11'h7FE, 32'hA1B2_C3D4, "R8", 0, 0, 0, 8'h00, 8'h00, rd);
        mem_op(1'b0, 2'b10, 11'h7FE, '0, "R8", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R8", "wrapped word", rd, 32'hA1B2_C3D4);
        mem_op(1'b0, 2'b01, 11'h000, '0, "R8", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R8", "wrapped high half", rd, 32'h0000_A1B2);

        // R10: config write in the accept cycle, then during flight
        lat = 1;
        mem_op(1'b0, 2'b00, 11'h010, '0, "R10", 1, 0, 0, 8'h34, 8'h01, rd);
        mem_op(1'b0, 2'b00, 11'h010, '0, "R10", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R10", "new segment used next", rd, 32'h0000_0011);
        lat = 3;
        mem_op(1'b0, 2'b10, 11'h010, '0, "R10", 0, 1, 0, 8'h30, 8'h13, rd);
        chk("R10", "in-flight word kept old window", rd, 32'h4433_2211);
        mem_op(1'b1, 2'b00, 11'h020, 32'h0000_00C7, "R10", 0, 0, 0, 8'h00, 8'h00, rd);
        cfg_chk(8'h30, 8'h13, "R10");

        // R11: request during wait is ignored
        lat = 2;
        mem_op(1'b1, 2'b01, 11'h030, 32'h0000_9A9A, "R11", 0, 0, 1, 8'h00, 8'h00, rd);
        repeat (4) @(negedge clk);
        chk("R11", "bus idle after ignored request", {31'd0, bp_req}, 32'd0);
        mem_op(1'b0, 2'b01, 11'h030, '0, "R11", 0, 0, 0, 8'h00, 8'h00, rd);
        chk("R11", "data unaffected by ignored request", rd, 32'h0000_9A9A);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule